// File: doc/BRIEF.md
# Fail-Safe Thermal Fan Override

This block guards a fan against a missing or faulty software thermal policy. Two temperature channels, one internal and one remote, each deliver conversion results with a one-cycle strobe. Each result is compared against that channel's active over-temperature limit. When a channel stays above its limit for enough consecutive readings, the block latches an override. The override drives the fan to full scale, raises that channel's over-temperature output and suppresses the fan-off request.

Each channel has two limits. One is a hard-wired default that cannot be changed. The other is a user limit that software writes through a small register port. A sticky lock bit chooses between them. While the lock is clear, the defaults are in force and the user registers can be written freely. Once software sets the lock, the user values become the active limits and can no longer be written. Only a reset clears the lock. An active override releases only after several consecutive readings that sit a fixed margin below the limit.

Top module: `thermal_failsafe`

## Requirements
- R1: After power-on reset (`rst_ni` low) or a one-cycle pulse on `sys_rst_i` or `aux_rst_i`, the block is in its reset state: `force_full_o`, `ovt_loc_o` and `ovt_rem_o` are 0, the lock is clear, the user internal limit is 70 and the user remote limit is 100.
- R2: While the lock is clear, the active limits are the fixed defaults (internal 70, remote 100). Writes to the user registers have no effect on when an override activates.
- R3: A write to address 0x40 with data bit 3 set sets the lock. From then on, the user registers are the active limits: address 0x13 holds the internal limit and address 0x14 holds the remote limit. A write to 0x40 with bit 3 clear does nothing.
- R4: While the lock is set, writes to 0x13 and 0x14 are ignored, and the active limits keep their locked values.
- R5: Once set, the lock stays set until `rst_ni`, `sys_rst_i` or `aux_rst_i` clears it.
- R6: Temperatures are unsigned 8-bit values in degrees. A channel that is not overridden activates its override on its third consecutive strobed reading that is strictly greater than its active limit. Any strobed reading at or below the limit restarts the count.
- R7: An active channel releases on its third consecutive strobed reading where temperature + 5 ≤ limit. Any other strobed reading restarts the release count.
- R8: The two channels count independently, and `force_full_o` is the OR of the two channel override states.
- R9: `ovt_loc_o` and `ovt_rem_o` follow their channel's override state directly. They change on the same clock edge as `force_full_o`, one edge after the deciding strobe.
- R10: `fan_off_o` equals `fan_off_req_i` while `force_full_o` is 0, and is 0 while `force_full_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_i | input | 1 | Synchronous system reset, active high |
| aux_rst_i | input | 1 | Synchronous auxiliary reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| loc_vld_i | input | 1 | Internal reading strobe |
| loc_temp_i | input | 8 | Internal temperature reading |
| rem_vld_i | input | 1 | Remote reading strobe |
| rem_temp_i | input | 8 | Remote temperature reading |
| fan_off_req_i | input | 1 | Fan-off request from normal control |
| force_full_o | output | 1 | Fan drive forced to full scale |
| ovt_loc_o | output | 1 | Internal channel over-temperature |
| ovt_rem_o | output | 1 | Remote channel over-temperature |
| fan_off_o | output | 1 | Fan-off request after the override gate |

## Verification
The release path is the hardest state to reach from the ports. It needs an override already active, followed by three readings in a row at least five degrees under the limit, and all of this under whichever limit set the lock currently selects. Directed sequences first set the lock with user limits well away from the defaults. They then drive over and cool runs that include a broken run. Random stimulus picks temperatures in a narrow band around the active limit, so runs of both kinds occur often and are cut short often. Random user writes after the lock and random resets check that the frozen values and the lock clearing behave as required.

// File: rtl/thermal_fs_pkg.sv
package thermal_fs_pkg;
    localparam int TEMP_W = 8;
    localparam int ADDR_W = 8;

    typedef logic [TEMP_W-1:0] temp_t;

    typedef struct packed {
        logic  locked;
        temp_t ulim_loc;
        temp_t ulim_rem;
    } cfg_st_t;
endpackage

// File: rtl/thermal_fs_cfg.sv
module thermal_fs_cfg
    import thermal_fs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_ULOC = 8'h13,
    parameter logic [ADDR_W-1:0] ADDR_UREM = 8'h14,
    parameter logic [ADDR_W-1:0] ADDR_CFG  = 8'h40,
    parameter int                LOCK_BIT  = 3,
    parameter temp_t             DEF_LOC   = 8'd70,
    parameter temp_t             DEF_REM   = 8'd100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [TEMP_W-1:0] wr_data_i,
    output temp_t             lim_loc_o,
    output temp_t             lim_rem_o
);
    localparam cfg_st_t CFG_RST = '{locked: 1'b0, ulim_loc: DEF_LOC, ulim_rem: DEF_REM};

    cfg_st_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (clr_i) begin
            cfg_d = CFG_RST;
        end else if (wr_en_i) begin
            if (!cfg_q.locked && wr_addr_i == ADDR_ULOC) cfg_d.ulim_loc = wr_data_i;
            if (!cfg_q.locked && wr_addr_i == ADDR_UREM) cfg_d.ulim_rem = wr_data_i;
            if (wr_addr_i == ADDR_CFG && wr_data_i[LOCK_BIT]) cfg_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= CFG_RST;
        else         cfg_q <= cfg_d;
    end

    assign lim_loc_o = cfg_q.locked ? cfg_q.ulim_loc : DEF_LOC;
    assign lim_rem_o = cfg_q.locked ? cfg_q.ulim_rem : DEF_REM;

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q.locked && !clr_i |=> cfg_q.locked); // R5
    AST_USER_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_q.locked && !clr_i |=> $stable(cfg_q.ulim_loc) && $stable(cfg_q.ulim_rem)); // R4
    AST_LOCK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cfg_q.locked) |-> $past(wr_en_i && wr_addr_i == ADDR_CFG)); // R3
endmodule

// File: rtl/thermal_fs_chan.sv
module thermal_fs_chan
    import thermal_fs_pkg::*;
#(
    parameter int PERSIST = 3,
    parameter int HYST    = 5
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  clr_i,
    input  logic  vld_i,
    input  temp_t temp_i,
    input  temp_t limit_i,
    output logic  active_o
);
    localparam int CW = $clog2(PERSIST + 1);
    localparam int XW = TEMP_W + 1;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] run;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     over, cool, hit;

    assign over = temp_i > limit_i;
    assign cool = ({1'b0, temp_i} + XW'(HYST)) <= {1'b0, limit_i};
    assign hit  = st_q.active ? cool : over;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (vld_i) begin
            if (!hit) begin
                st_d.run = '0;
            end else if (st_q.run == CW'(PERSIST - 1)) begin
                st_d.run    = '0;
                st_d.active = !st_q.active;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign active_o = st_q.active;

    AST_RISE_ON_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.active) |-> $past(vld_i && over && !clr_i)); // R6
    AST_FALL_ON_COOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.active) |-> $past(clr_i) || $past(vld_i && cool)); // R7
    AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.run < CW'(PERSIST)); // R6
    AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld_i && !clr_i |=> $stable(st_q)); // R6
endmodule

// File: rtl/thermal_failsafe.sv
module thermal_failsafe
    import thermal_fs_pkg::*;
#(
    parameter int PERSIST = 3,
    parameter int HYST    = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sys_rst_i,
    input  logic              aux_rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [TEMP_W-1:0] wr_data_i,
    input  logic              loc_vld_i,
    input  logic [TEMP_W-1:0] loc_temp_i,
    input  logic              rem_vld_i,
    input  logic [TEMP_W-1:0] rem_temp_i,
    input  logic              fan_off_req_i,
    output logic              force_full_o,
    output logic              ovt_loc_o,
    output logic              ovt_rem_o,
    output logic              fan_off_o
);
    localparam int NCH = 2;

    logic  clr;
    temp_t lim_loc, lim_rem;
    logic  [NCH-1:0] vld, act;
    temp_t [NCH-1:0] temp, lim;

    assign clr  = sys_rst_i | aux_rst_i;
    assign vld  = {rem_vld_i, loc_vld_i};
    assign temp = {rem_temp_i, loc_temp_i};
    assign lim  = {lim_rem, lim_loc};

    thermal_fs_cfg i_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (clr),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .lim_loc_o (lim_loc),
        .lim_rem_o (lim_rem)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        thermal_fs_chan #(.PERSIST(PERSIST), .HYST(HYST)) i_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clr_i    (clr),
            .vld_i    (vld[g]),
            .temp_i   (temp[g]),
            .limit_i  (lim[g]),
            .active_o (act[g])
        );
    end

    assign ovt_loc_o    = act[0];
    assign ovt_rem_o    = act[1];
    assign force_full_o = |act;
    assign fan_off_o    = fan_off_req_i & ~force_full_o;

    AST_FANOFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        force_full_o |-> !fan_off_o); // R10
    AST_FORCE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(force_full_o) |-> $past(loc_vld_i || rem_vld_i)); // R8
    AST_CLEAR_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr |=> !force_full_o && !ovt_loc_o && !ovt_rem_o); // R1
endmodule

// File: tb/test_thermal_failsafe.sv
`timescale 1ns/1ps
module test_thermal_failsafe;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, sys_rst = 1'b0, aux_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0;
    logic       loc_vld = 1'b0, rem_vld = 1'b0;
    logic [7:0] loc_temp = '0, rem_temp = '0;
    logic       fan_req = 1'b0;
    logic       force_full, ovt_loc, ovt_rem, fan_off;

    int  checks = 0, fails = 0;
    bit  done = 1'b0;

    // bench model: index 0 internal, 1 remote
    bit       m_lock;
    int       m_user[2];
    bit       m_act[2];
    int       m_run[2];
    const int DEF[2] = '{70, 100};

    always #2 clk = ~clk;

    thermal_failsafe i_thermal_failsafe (
        .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst), .aux_rst_i(aux_rst),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .loc_vld_i(loc_vld), .loc_temp_i(loc_temp), .rem_vld_i(rem_vld), .rem_temp_i(rem_temp),
        .fan_off_req_i(fan_req), .force_full_o(force_full), .ovt_loc_o(ovt_loc),
        .ovt_rem_o(ovt_rem), .fan_off_o(fan_off));

    function automatic void model_reset();
        m_lock = 0; m_user[0] = 70; m_user[1] = 100;
        m_act = '{0, 0}; m_run = '{0, 0};
    endfunction

    function automatic int active_limit(int ch);
        return m_lock ? m_user[ch] : DEF[ch];
    endfunction

    function automatic void model_sample(int ch, int t);
        int  lim = active_limit(ch);
        bit  hit = m_act[ch] ? (t + 5 <= lim) : (t > lim);
        if (!hit) m_run[ch] = 0;
        else if (m_run[ch] == 2) begin m_run[ch] = 0; m_act[ch] = !m_act[ch]; end
        else m_run[ch]++;
    endfunction

    function automatic void model_write(int a, int d);
        if (!m_lock && a == 'h13) m_user[0] = d;
        if (!m_lock && a == 'h14) m_user[1] = d;
        if (a == 'h40 && d[3]) m_lock = 1;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        bit f = m_act[0] || m_act[1];
        check(tag, "force_full (R8)", force_full, f);
        check(tag, "ovt_loc (R9)", ovt_loc, m_act[0]);
        check(tag, "ovt_rem (R9)", ovt_rem, m_act[1]);
        check(tag, "fan_off (R10)", fan_off, fan_req && !f);
    endtask

    task automatic sample(int ch, int t, string tag);
        @(negedge clk);
        if (ch == 0) begin loc_vld = 1; loc_temp = 8'(t); end
        else begin rem_vld = 1; rem_temp = 8'(t); end
        fan_req = 1'($urandom);
        @(posedge clk);
        model_sample(ch, t);
        @(negedge clk);
        loc_vld = 0; rem_vld = 0;
        check_all(tag);
    endtask

    task automatic write(int a, int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 8'(a); wr_data = 8'(d);
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_reset(int kind);
        @(negedge clk);
        if (kind == 0) rst_n = 0;
        else if (kind == 1) sys_rst = 1;
        else aux_rst = 1;
        @(negedge clk);
        rst_n = 1; sys_rst = 0; aux_rst = 0;
        model_reset();
        check_all("R1");
    endtask

    task automatic run(int ch, int t, int n, string tag);
        for (int i = 0; i < n; i++) sample(ch, t, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R2: user writes before lock leave defaults in force
        write('h14, 50); write('h13, 40);
        run(1, 60, 3, "R2"); run(0, 50, 3, "R2");
        // R6: broken run restarts, then three over readings activate
        run(1, 101, 2, "R6"); sample(1, 100, "R6"); run(1, 101, 2, "R6");
        sample(1, 101, "R6");
        // R8: internal channel independent
        run(0, 71, 3, "R8");
        // R7: release needs three at limit-5; limit-4 breaks the run
        run(1, 95, 2, "R7"); sample(1, 96, "R7"); run(1, 95, 3, "R7");
        run(0, 65, 3, "R7");

        // R3: lock with bit3 clear does nothing, bit3 set locks in user limits
        do_reset(1);
        write('h13, 30); write('h14, 120);
        write('h40, 'hF7);
        run(0, 35, 3, "R3");
        write('h40, 'h08);
        run(0, 35, 3, "R3");
        // R4: writes after lock ignored
        write('h13, 200); write('h14, 10);
        run(1, 110, 3, "R4"); run(0, 25, 3, "R4");
        // R5: lock survives config rewrites, cleared by each reset
        write('h40, 'h00);
        run(1, 121, 3, "R5"); run(1, 115, 3, "R5");
        do_reset(2);
        run(1, 101, 3, "R5");
        do_reset(0);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            int op = $urandom_range(0, 99);
            if (op < 80) begin
                int ch = $urandom_range(0, 1);
                int t  = active_limit(ch) + $urandom_range(0, 16) - 8;
                if (t < 0) t = 0;
                if (t > 255) t = 255;
                sample(ch, t, "R6/R7");
            end else if (op < 95) begin
                int sel = $urandom_range(0, 2);
                int a = (sel == 0) ? 'h13 : (sel == 1) ? 'h14 : 'h40;
                int d = (sel == 2) ? (($urandom_range(0, 3) == 0) ? 'h08 : 'h00)
                                   : $urandom_range(40, 130);
                write(a, d);
            end else if (op < 97) begin
                do_reset($urandom_range(0, 2));
            end else begin
                @(negedge clk); fan_req = 1'($urandom);
                check_all("R10");
            end
        end
        finish_run();
    end
endmodule